// File: doc/BRIEF.md
# Nested Priority Save Stack

This block keeps the running priority of an interrupted routine while a higher-priority routine runs. Each time the parent controller accepts an interrupt it strobes `push_i` with the priority that was current at that moment. Each time an end-of-interrupt is signalled it strobes `pop_i` and loads `pop_prio_o` back into its current-priority register. Because the saved priorities live inside the controller, an interrupt handler does not have to save and restore the priority on its own stack.

The store is a fixed number of entries deep, 14 by default. Two rules replace overflow and underflow handling. A push onto a full store drops the oldest saved value. A pop from an empty store returns priority 0. Level 15 is never preempted, so at most 15 nesting levels exist, and the lowest of them is always 0. A 14-entry store therefore rebuilds all 15 levels. The parent logic chooses where the push strobe comes from (a register read or a processor acknowledge line) and decodes the bus. Neither of these is part of this block.

Top module: `nested_prio_stack`

## Requirements
- R1: Synchronous active-low reset empties the store. In the first cycle after reset, `pop_prio_o` is 0.
- R2: A push alone (`push_i`=1, `pop_i`=0) at a clock edge makes `pop_prio_o` equal the pushed `push_prio_i` value from the next cycle on.
- R3: `pop_prio_o` always shows the most recently saved priority that has not been popped. A pop alone removes that value, and the value saved before it then appears on `pop_prio_o` in the next cycle (last-in, first-out order).
- R4: When the store is empty, `pop_prio_o` is 0. A pop on an empty store returns 0 and leaves the store empty.
- R5: The store holds `STACK_DEPTH` entries (default 14). A push onto a full store discards the oldest entry and keeps the newest `STACK_DEPTH` values. After the newest `STACK_DEPTH` values have been popped in order, further pops return 0.
- R6: The occupancy never exceeds `STACK_DEPTH`, never goes below 0, and never wraps.
- R7: When push and pop are both asserted in the same cycle, the pop is applied first and then the push. The caller receives the current `pop_prio_o`, the top entry is replaced by `push_prio_i`, and the occupancy stays the same. On an empty store the same operation leaves one entry, holding `push_prio_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Save `push_prio_i` at this edge |
| pop_i | input | 1 | Remove the top entry at this edge |
| push_prio_i | input | PRIO_W | Priority value to save |
| pop_prio_o | output | PRIO_W | Top saved priority, or 0 when empty; valid in the cycle a pop is strobed |

## Verification
The value returned by a pop is the `pop_prio_o` level in the same cycle as the strobe, so the bench compares it at the falling edge before the pop edge. The effect of any push, pop or combined operation is visible on `pop_prio_o` one register stage later. The bench clears the strobes at the next falling edge and compares the new top there. A reference store in the bench, built only from the requirements, supplies each expected value. Directed runs cover reset, overfill by one, draining past empty, and a combined operation on an empty store. Seeded random operations then cover the remaining cases.

// File: rtl/nps_pkg.sv
// Shared types for the nested priority save stack.
package nps_pkg;
    // Operation applied to the store at one clock edge.
    typedef enum logic [1:0] {
        NPS_IDLE = 2'b00,
        NPS_PUSH = 2'b01,
        NPS_POP  = 2'b10,
        NPS_SWAP = 2'b11   // pop then push in one edge
    } nps_op_e;
endpackage

// File: rtl/nps_op_decode.sv
// Turns the push and pop strobes into one operation code.
// Assumes the strobes are synchronous to clk; a combined strobe means
// pop first, then push.
module nps_op_decode
    import nps_pkg::*;
(
    input  logic    push_i,
    input  logic    pop_i,
    output nps_op_e op_o
);
    // Map the strobe pair onto the operation encoding.
    always_comb begin
        unique case ({pop_i, push_i})
            2'b01:   op_o = NPS_PUSH;
            2'b10:   op_o = NPS_POP;
            2'b11:   op_o = NPS_SWAP;
            default: op_o = NPS_IDLE;
        endcase
    end
endmodule

// File: rtl/nps_level_counter.sv
// Saturating occupancy counter for the save stack.
// Assumes DEPTH >= 1. It never wraps: pushes stop at DEPTH and pops stop at 0.
module nps_level_counter
    import nps_pkg::*;
#(
    parameter int DEPTH = 14,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  nps_op_e       op_i,
    output logic [CW-1:0] count_o
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [CW-1:0] count_q;
    logic [CW-1:0] count_d;

    // Work out the next occupancy with saturation at both ends.
    always_comb begin
        count_d = count_q;
        unique case (op_i)
            NPS_PUSH: if (count_q != FULL) count_d = count_q + 1'b1;
            NPS_POP:  if (count_q != '0)   count_d = count_q - 1'b1;
            NPS_SWAP: if (count_q == '0)   count_d = CW'(1);
            default:  count_d = count_q;
        endcase
    end

    // Hold the occupancy; reset empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count_o = count_q;

    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> count_q == '0);

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL);

    a_r6_push_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == NPS_PUSH && count_q == FULL) |=> count_q == FULL);

    a_r4_pop_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == NPS_POP && count_q == '0) |=> count_q == '0);

    a_r7_swap_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == NPS_SWAP && count_q != '0) |=> $stable(count_q));
endmodule

// File: rtl/nps_shift_store.sv
// Entry storage for the save stack, built as a shift register.
// Slot 0 is the top and the highest slot is the oldest. A push shifts
// toward the bottom and drops the oldest entry. A pop shifts toward the
// top and refills the bottom slot with zero, so empty slots read as 0.
// Assumes DEPTH >= 2.
module nps_shift_store
    import nps_pkg::*;
#(
    parameter int DEPTH  = 14,
    parameter int PRIO_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  nps_op_e           op_i,
    input  logic [PRIO_W-1:0] din_i,
    output logic [PRIO_W-1:0] top_o
);
    localparam int LAST = DEPTH - 1;

    logic [PRIO_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [PRIO_W-1:0] above;
        logic [PRIO_W-1:0] below;

        if (g == 0) begin : g_top
            assign above = din_i;
        end else begin : g_mid
            assign above = slot_q[g-1];
        end

        if (g == LAST) begin : g_bottom
            assign below = '0;
        end else begin : g_inner
            assign below = slot_q[g+1];
        end

        // Load one slot according to the operation; reset clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else begin
                unique case (op_i)
                    NPS_PUSH: slot_q[g] <= above;
                    NPS_POP:  slot_q[g] <= below;
                    NPS_SWAP: if (g == 0) slot_q[g] <= din_i;
                    default:  slot_q[g] <= slot_q[g];
                endcase
            end
        end
    end

    assign top_o = slot_q[0];

    a_r2_push_lands_on_top: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == NPS_PUSH || op_i == NPS_SWAP) |=> top_o == $past(din_i));

    a_r3_pop_exposes_next: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == NPS_POP) |=> top_o == $past(slot_q[1]));

    a_r3_idle_holds_top: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == NPS_IDLE) |=> $stable(top_o));
endmodule

// File: rtl/nested_prio_stack.sv
// Nested priority save stack: saves preempted priorities on push and
// returns them on pop. A full store drops its oldest entry, and an empty
// store returns 0. Assumes single-cycle strobes in clk and a synchronous
// active-low reset.
module nested_prio_stack #(
    parameter int STACK_DEPTH = 14,
    parameter int PRIO_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [PRIO_W-1:0] push_prio_i,
    output logic [PRIO_W-1:0] pop_prio_o
);
    import nps_pkg::*;

    localparam int CW = $clog2(STACK_DEPTH + 1);

    nps_op_e       op;
    logic [CW-1:0] level;
    logic [PRIO_W-1:0] top;

    nps_op_decode u_decode (
        .push_i (push_i),
        .pop_i  (pop_i),
        .op_o   (op)
    );

    nps_level_counter #(.DEPTH(STACK_DEPTH)) u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (op),
        .count_o (level)
    );

    nps_shift_store #(.DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .op_i  (op),
        .din_i (push_prio_i),
        .top_o (top)
    );

    assign pop_prio_o = top;

    a_r4_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> pop_prio_o == '0);

    a_r5_full_push_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && level == CW'(STACK_DEPTH)) |=> level == CW'(STACK_DEPTH));
endmodule

// File: tb/nested_prio_stack_bench.sv
`timescale 1ns/1ps
module nested_prio_stack_bench;
    localparam int DEPTH = 14;
    localparam int PW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push = 1'b0;
    logic          pop = 1'b0;
    logic [PW-1:0] din = '0;
    logic [PW-1:0] dout;

    int total = 0;
    int bad = 0;

    // Reference store: m[0] is the top; cnt is the occupancy.
    logic [PW-1:0] m [DEPTH];
    int cnt = 0;

    always #2.5 clk = ~clk;

    nested_prio_stack #(.STACK_DEPTH(DEPTH), .PRIO_W(PW)) u_nested_prio_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .pop_i       (pop),
        .push_prio_i (din),
        .pop_prio_o  (dout)
    );

    function automatic logic [PW-1:0] model_top();
        return (cnt == 0) ? '0 : m[0];
    endfunction

    task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m[i] = '0;
        cnt = 0;
    endtask

    // Apply the operation to the reference store: pop first, then push.
    task automatic model_apply(input logic p, input logic q, input logic [PW-1:0] v);
        if (q && cnt > 0) begin
            for (int i = 0; i < DEPTH - 1; i++) m[i] = m[i+1];
            m[DEPTH-1] = '0;
            cnt--;
        end
        if (p) begin
            for (int i = DEPTH - 1; i > 0; i--) m[i] = m[i-1];
            m[0] = v;
            if (cnt < DEPTH) cnt++;
        end
    endtask

    // One operation, called at a falling edge: check the returned value,
    // clock it in, then check the new top at the next falling edge.
    task automatic op(input logic p, input logic q, input logic [PW-1:0] v, input string req);
        push = p; pop = q; din = v;
        if (q) chk(req, dout, model_top());
        model_apply(p, q, v);
        @(negedge clk);
        push = 1'b0; pop = 1'b0;
        chk(req, dout, model_top());
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", dout, '0);

        // R4: pop on empty returns 0 and leaves it empty
        op(1'b0, 1'b1, '0, "R4");
        op(1'b0, 1'b1, '0, "R4");

        // R2/R3: short push then pop sequence
        op(1'b1, 1'b0, 4'd3, "R2");
        op(1'b1, 1'b0, 4'd7, "R2");
        op(1'b0, 1'b1, '0, "R3");
        op(1'b0, 1'b1, '0, "R3");
        op(1'b0, 1'b1, '0, "R4");

        // R5/R6: overfill by one, then drain past empty
        for (int i = 1; i <= DEPTH + 1; i++) op(1'b1, 1'b0, PW'(i), "R5");
        for (int i = 0; i < DEPTH + 2; i++) op(1'b0, 1'b1, '0, "R6");

        // R7: combined operation on empty, then on a non-empty store
        op(1'b1, 1'b1, 4'd9, "R7");
        op(1'b1, 1'b0, 4'd5, "R7");
        op(1'b1, 1'b1, 4'd12, "R7");
        op(1'b0, 1'b1, '0, "R7");
        op(1'b0, 1'b1, '0, "R7");
        op(1'b0, 1'b1, '0, "R4");

        // Random mix, biased toward pushes so the store fills and overflows
        for (int n = 0; n < 3000; n++) begin
            int r;
            logic p, q;
            r = int'($urandom_range(0, 9));
            p = (r < 5) || (r == 9);
            q = (r >= 5);
            op(p, q, PW'($urandom_range(0, 15)), "R3");
        end

        // Reset mid-run empties the store
        for (int i = 0; i < 4; i++) op(1'b1, 1'b0, PW'(i + 2), "R2");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        chk("R1", dout, '0);
        op(1'b0, 1'b1, '0, "R1");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule